// File: doc/BRIEF.md
# Broadcast Snoop Response Collector

This block follows a single last-level-cache miss raised by one partition of a cache split into several partitions. In peer-to-peer mode it sends the miss out once on a broadcast request output. It then gathers an Ack or Nack vote from every other partition into a per-partition bitmap. An Ack means the voting partition holds the line as its supplier. When exactly one supplier Acks, the collector waits for that partition's cache-to-cache data. When no partition Acks, the collector turns the same miss into a mediated request. That request is a unicast to one coherence gateway, picked from two address bits, so a given line always maps to the same gateway. More than one supplier Ack is a protocol error: the collector raises an error pulse and takes the mediated path.

A miss can also be issued straight in mediated mode, which skips the broadcast. The collector tracks one miss at a time. It refuses new misses until the data for the current one has arrived, and it then signals completion together with a bit that gives the data source.

Top module: `snoop_collector`

## Requirements
- R1: After reset `miss_ready_o` is 1 and `bcast_valid_o`, `gw_valid_o`, `done_o` and `err_o` are 0.
- R2: A miss accepted with `miss_mediated_i`=0 raises `bcast_valid_o` for exactly the next cycle, with `bcast_addr_o` equal to the miss address. `miss_ready_o` stays 0 from that cycle until completion.
- R3: Votes from the requester's own slot (index `SELF_ID`, default 0) are ignored. No decision is taken until all remote slots have voted, and votes may arrive in any mix of cycles.
- R4: When exactly one remote Ack is collected, no gateway request and no error are issued, and the collector waits for cache-to-cache data.
- R5: When no remote Ack is collected, `gw_valid_o` is 1 for one cycle, the cycle after the final vote. In that cycle `gw_addr_o` is the miss address and `gw_sel_o` is address bits [GW_LSB+1:GW_LSB] (default [7:6]).
- R6: When two or more remote Acks are collected, `err_o` pulses for one cycle, in the same cycle as the gateway request of the fallback.
- R7: A miss accepted with `miss_mediated_i`=1 raises `gw_valid_o` in the next cycle with the gateway index of R5, and no broadcast is sent.
- R8: While waiting, a data return whose `data_mem_i` does not match the expected source (0 = supplier partition, 1 = memory) is ignored. On the matching return, `done_o` pulses in the next cycle with `done_c2c_o` = NOT `data_mem_i`, and `miss_ready_o` returns to 1.
- R9: A miss presented while `miss_ready_o` is 0 is refused and produces no broadcast and no gateway request.
- R10: A second vote from a slot that has already voted in the same collection is ignored, including an Ack that follows a Nack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| miss_valid_i | input | 1 | miss request present |
| miss_mediated_i | input | 1 | 1 = issue directly as mediated request |
| miss_addr_i | input | ADDR_W | miss line address |
| miss_ready_o | output | 1 | collector idle, miss accepted |
| bcast_valid_o | output | 1 | broadcast request strobe |
| bcast_addr_o | output | ADDR_W | broadcast request address |
| resp_valid_i | input | N_PART | per-partition vote strobe |
| resp_ack_i | input | N_PART | per-partition vote, 1 = Ack as supplier |
| gw_valid_o | output | 1 | gateway unicast request strobe |
| gw_sel_o | output | GW_W | target gateway index |
| gw_addr_o | output | ADDR_W | gateway request address |
| data_valid_i | input | 1 | data return strobe |
| data_mem_i | input | 1 | data return source, 1 = memory |
| done_o | output | 1 | completion pulse |
| done_c2c_o | output | 1 | completion came from a supplier partition |
| err_o | output | 1 | multiple-supplier protocol error pulse |

## Verification
Four vote patterns exercise the decision. The first has one supplier, with the votes spread over several cycles; the own slot Acks in it, and one slot votes twice, so any counting of ignored votes shows up as a spurious fallback. The second has all Nacks in a single cycle, which must take the gateway path. The third has two Acks, which must take the error and the fallback path. Directly mediated misses sweep every gateway index to confirm the address slice. Data returns from the wrong source and misses presented while busy show that neither one ends or restarts the current miss early.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_BCAST,
    S_COLLECT,
    S_GW,
    S_WAIT_C2C,
    S_WAIT_MEM
  } snp_state_e;
endpackage

// File: rtl/snp_vote_tracker.sv
module snp_vote_tracker #(
  parameter int N_PART  = 8,
  parameter int SELF_ID = 0,
  localparam int CNT_W  = $clog2(N_PART + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [N_PART-1:0] resp_valid_i,
  input  logic [N_PART-1:0] resp_ack_i,
  output logic              all_in_o,
  output logic [CNT_W-1:0]  ack_cnt_o
);
  localparam logic [N_PART-1:0] REMOTE = ~(N_PART'(1) << SELF_ID);

  logic [N_PART-1:0] seen_q, ack_q, seen_n, ack_n, fresh;

  // first vote per remote slot counts, repeats dropped
  assign fresh  = en_i ? (resp_valid_i & REMOTE & ~seen_q) : '0;
  assign seen_n = seen_q | fresh;
  assign ack_n  = ack_q | (fresh & resp_ack_i);
  assign all_in_o = ((seen_n & REMOTE) == REMOTE);

  always_comb begin
    ack_cnt_o = '0;
    for (int i = 0; i < N_PART; i++) ack_cnt_o = ack_cnt_o + CNT_W'(ack_n[i]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= '0;
      ack_q  <= '0;
    end else if (clr_i) begin
      seen_q <= '0;
      ack_q  <= '0;
    end else begin
      seen_q <= seen_n;
      ack_q  <= ack_n;
    end
  end
endmodule

// File: rtl/snp_ctrl.sv
module snp_ctrl
  import snp_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int N_PART = 8,
  localparam int CNT_W = $clog2(N_PART + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic              miss_mediated_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic              all_in_i,
  input  logic [CNT_W-1:0]  ack_cnt_i,
  input  logic              data_valid_i,
  input  logic              data_mem_i,
  output logic              miss_ready_o,
  output logic              bcast_valid_o,
  output logic              gw_valid_o,
  output logic              clr_o,
  output logic              collect_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              done_c2c_o,
  output logic              err_o
);
  snp_state_e state_q, state_n;
  logic [ADDR_W-1:0] addr_q;
  logic done_n, c2c_n, err_n;

  assign miss_ready_o  = (state_q == S_IDLE);
  assign bcast_valid_o = (state_q == S_BCAST);
  assign gw_valid_o    = (state_q == S_GW);
  assign clr_o         = (state_q == S_BCAST);
  assign collect_o     = (state_q == S_COLLECT);
  assign addr_o        = addr_q;

  always_comb begin
    state_n = state_q;
    done_n  = 1'b0;
    c2c_n   = 1'b0;
    err_n   = 1'b0;
    unique case (state_q)
      S_IDLE:
        if (miss_valid_i) state_n = miss_mediated_i ? S_GW : S_BCAST;
      S_BCAST:   state_n = S_COLLECT;
      S_COLLECT:
        if (all_in_i) begin
          if (ack_cnt_i == CNT_W'(1)) state_n = S_WAIT_C2C;
          else begin
            state_n = S_GW;
            err_n   = (ack_cnt_i > CNT_W'(1));
          end
        end
      S_GW:      state_n = S_WAIT_MEM;
      S_WAIT_C2C:
        if (data_valid_i && !data_mem_i) begin
          state_n = S_IDLE;
          done_n  = 1'b1;
          c2c_n   = 1'b1;
        end
      S_WAIT_MEM:
        if (data_valid_i && data_mem_i) begin
          state_n = S_IDLE;
          done_n  = 1'b1;
        end
      default:   state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      addr_q     <= '0;
      done_o     <= 1'b0;
      done_c2c_o <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      state_q    <= state_n;
      done_o     <= done_n;
      done_c2c_o <= c2c_n;
      err_o      <= err_n;
      if (state_q == S_IDLE && miss_valid_i) addr_q <= miss_addr_i;
    end
  end
endmodule

// File: rtl/snoop_collector.sv
module snoop_collector #(
  parameter int ADDR_W  = 40,
  parameter int N_PART  = 8,
  parameter int N_GW    = 4,
  parameter int SELF_ID = 0,
  parameter int GW_LSB  = 6,
  localparam int GW_W   = (N_GW > 1) ? $clog2(N_GW) : 1,
  localparam int CNT_W  = $clog2(N_PART + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic              miss_mediated_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              miss_ready_o,
  output logic              bcast_valid_o,
  output logic [ADDR_W-1:0] bcast_addr_o,
  input  logic [N_PART-1:0] resp_valid_i,
  input  logic [N_PART-1:0] resp_ack_i,
  output logic              gw_valid_o,
  output logic [GW_W-1:0]   gw_sel_o,
  output logic [ADDR_W-1:0] gw_addr_o,
  input  logic              data_valid_i,
  input  logic              data_mem_i,
  output logic              done_o,
  output logic              done_c2c_o,
  output logic              err_o
);
  logic              clr, collect, all_in;
  logic [CNT_W-1:0]  ack_cnt;
  logic [ADDR_W-1:0] addr;

  snp_vote_tracker #(.N_PART(N_PART), .SELF_ID(SELF_ID)) u_votes (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .en_i         (collect),
    .resp_valid_i (resp_valid_i),
    .resp_ack_i   (resp_ack_i),
    .all_in_o     (all_in),
    .ack_cnt_o    (ack_cnt)
  );

  snp_ctrl #(.ADDR_W(ADDR_W), .N_PART(N_PART)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .miss_valid_i    (miss_valid_i),
    .miss_mediated_i (miss_mediated_i),
    .miss_addr_i     (miss_addr_i),
    .all_in_i        (all_in),
    .ack_cnt_i       (ack_cnt),
    .data_valid_i    (data_valid_i),
    .data_mem_i      (data_mem_i),
    .miss_ready_o    (miss_ready_o),
    .bcast_valid_o   (bcast_valid_o),
    .gw_valid_o      (gw_valid_o),
    .clr_o           (clr),
    .collect_o       (collect),
    .addr_o          (addr),
    .done_o          (done_o),
    .done_c2c_o      (done_c2c_o),
    .err_o           (err_o)
  );

  assign bcast_addr_o = addr;
  assign gw_addr_o    = addr;

  generate
    if (N_GW > 1) begin : g_multi_gw
      assign gw_sel_o = addr[GW_LSB +: GW_W];
    end else begin : g_single_gw
      assign gw_sel_o = '0;
    end
  endgenerate
endmodule

// File: rtl/snp_chk.sv
module snp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic miss_valid_i,
  input logic miss_ready_o,
  input logic bcast_valid_o,
  input logic gw_valid_o,
  input logic data_valid_i,
  input logic done_o,
  input logic err_o
);
  // R2
  bcast_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_valid_o |=> !bcast_valid_o);
  // R2
  bcast_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_valid_o |-> !miss_ready_o);
  // R5
  gw_one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gw_valid_o |=> !gw_valid_o);
  // R7
  req_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bcast_valid_o && gw_valid_o));
  // R6
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> gw_valid_o);
  // R8
  done_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> miss_ready_o && $past(data_valid_i));
  // R9
  refuse_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && !miss_ready_o) |=> !bcast_valid_o);
endmodule

bind snoop_collector snp_chk u_snp_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .miss_valid_i  (miss_valid_i),
  .miss_ready_o  (miss_ready_o),
  .bcast_valid_o (bcast_valid_o),
  .gw_valid_o    (gw_valid_o),
  .data_valid_i  (data_valid_i),
  .done_o        (done_o),
  .err_o         (err_o)
);

// File: tb/tb_snoop_collector.sv
module tb_snoop_collector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0, miss_med = 1'b0;
  logic [39:0] miss_addr = '0;
  logic        miss_ready, bcast_valid, gw_valid;
  logic [39:0] bcast_addr, gw_addr;
  logic [1:0]  gw_sel;
  logic [7:0]  resp_valid = '0, resp_ack = '0;
  logic        data_valid = 1'b0, data_mem = 1'b0;
  logic        done, done_c2c, err;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  snoop_collector dut (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_mediated_i(miss_med), .miss_addr_i(miss_addr),
    .miss_ready_o(miss_ready), .bcast_valid_o(bcast_valid), .bcast_addr_o(bcast_addr),
    .resp_valid_i(resp_valid), .resp_ack_i(resp_ack),
    .gw_valid_o(gw_valid), .gw_sel_o(gw_sel), .gw_addr_o(gw_addr),
    .data_valid_i(data_valid), .data_mem_i(data_mem),
    .done_o(done), .done_c2c_o(done_c2c), .err_o(err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [39:0] a, logic med);
    @(negedge clk); miss_valid = 1'b1; miss_med = med; miss_addr = a;
    @(negedge clk); miss_valid = 1'b0; miss_med = 1'b0;
  endtask

  task automatic vote(logic [7:0] v, logic [7:0] a);
    @(negedge clk); resp_valid = v; resp_ack = a;
    @(negedge clk); resp_valid = '0; resp_ack = '0;
  endtask

  task automatic give_data(logic m);
    @(negedge clk); data_valid = 1'b1; data_mem = m;
    @(negedge clk); data_valid = 1'b0; data_mem = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready", miss_ready, 1);
    chk("R1 bcast", bcast_valid, 0);
    chk("R1 gw", gw_valid, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
  endtask

  task automatic t_supplier;
    logic [39:0] a = 40'h12_3456_7840;
    issue(a, 1'b0);
    chk("R2 bcast", bcast_valid, 1);
    chk("R2 addr", bcast_addr, a);
    chk("R2 busy", miss_ready, 0);
    vote(8'h0F, 8'h01);               // own slot 0 Acks: ignored
    chk("R3 partial gw", gw_valid, 0);
    chk("R2 bcast once", bcast_valid, 0);
    vote(8'h74, 8'h04);               // slot 2 votes again with Ack
    chk("R3 still waiting", gw_valid, 0);
    chk("R3 still busy", miss_ready, 0);
    vote(8'h80, 8'h80);
    chk("R4 no gw", gw_valid, 0);
    chk("R10 no err", err, 0);
    @(negedge clk);
    chk("R4 still no gw", gw_valid, 0);
    give_data(1'b1);
    chk("R8 wrong src ignored", done, 0);
    chk("R8 still busy", miss_ready, 0);
    give_data(1'b0);
    chk("R8 done", done, 1);
    chk("R8 c2c", done_c2c, 1);
    chk("R8 ready", miss_ready, 1);
    @(negedge clk);
    chk("R8 done pulse", done, 0);
  endtask

  task automatic t_fallback;
    logic [39:0] a = 40'hAB_CDEF_0180;
    issue(a, 1'b0);
    vote(8'hFE, 8'h00);
    chk("R5 gw", gw_valid, 1);
    chk("R5 sel", gw_sel, 2'b10);
    chk("R5 addr", gw_addr, a);
    chk("R5 no err", err, 0);
    issue(40'h0, 1'b0);                // refused while busy
    chk("R9 no bcast", bcast_valid, 0);
    chk("R9 no gw", gw_valid, 0);
    chk("R9 busy", miss_ready, 0);
    give_data(1'b0);
    chk("R8 c2c ignored", done, 0);
    give_data(1'b1);
    chk("R8 mem done", done, 1);
    chk("R8 mem src", done_c2c, 0);
  endtask

  task automatic t_multi;
    issue(40'h55_0000_00C0, 1'b0);
    vote(8'hFE, 8'h06);
    chk("R6 err", err, 1);
    chk("R6 gw", gw_valid, 1);
    chk("R6 sel", gw_sel, 2'b11);
    @(negedge clk);
    chk("R6 err pulse", err, 0);
    give_data(1'b1);
    chk("R6 done", done, 1);
  endtask

  task automatic t_mediated;
    for (int g = 0; g < 4; g++) begin
      logic [39:0] a = {32'h0BAD_F00D, g[1:0], 6'h15};
      issue(a, 1'b1);
      chk("R7 gw", gw_valid, 1);
      chk("R7 no bcast", bcast_valid, 0);
      chk("R7 sel", gw_sel, g[1:0]);
      chk("R7 addr", gw_addr, a);
      give_data(1'b1);
      chk("R7 done", done, 1);
      chk("R7 src", done_c2c, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_supplier();
    t_fallback();
    t_multi();
    t_mediated();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule